// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block translates a logical address into a physical address. The logical address is a segment number paired with an offset inside that segment. A small on-chip segment table holds one descriptor per segment. Each descriptor has a physical start address, a segment length, a present flag and three permission bits for read, write and execute. A segment-count register sets how many segments are usable. Any segment number at or above that count is rejected.

Lookups arrive over a valid/ready request channel and leave over a valid/ready response channel one cycle after acceptance. A response carries either a physical address or a fault code. The fault code identifies the first failed check, with the checks taken in a fixed priority order. A separate configuration port writes descriptors and the segment-count register. A configuration write lands on a clock edge. A lookup accepted on that same edge still sees the old table contents.

Top module: `segxl_unit`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1. The segment count is 0 and every descriptor is marked not present.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. Its response appears with rsp_valid=1 after that edge. req_ready is 1 when no response is pending or when rsp_ready is 1. rsp_valid drops after a response is taken with no new request accepted on the same edge.
- R3: While rsp_valid=1 and rsp_ready=0, rsp_fault and rsp_paddr hold steady, req_ready is 0, and no new request is taken.
- R4: A segment number greater than or equal to the segment count gives fault code 1.
- R5: A segment whose descriptor is not present gives fault code 2.
- R6: An offset greater than or equal to the descriptor length gives fault code 3. The length field is OFF_W+1 bits wide, so it can cover the full offset range.
- R7: The access code is 0 for read, 1 for write, 2 for execute and 3 for reserved. An access whose permission bit is clear gives fault code 4. The permission bits are bit 0 for read, bit 1 for write and bit 2 for execute. The reserved access code always gives fault code 4.
- R8: When several checks fail, the reported code follows this priority: range, then present, then length, then permission.
- R9: With no fault, rsp_fault is 0 and rsp_paddr is the descriptor base plus the offset, modulo 2^PA_W. On any fault, rsp_paddr is 0.
- R10: A descriptor write or segment-count write on the same edge as an accepted request does not affect that request. It does affect the next one.
- R11: Writing the segment-count register changes which segment numbers pass the range check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ent_we | input | 1 | Write enable for one descriptor |
| cfg_idx | input | SEG_W | Descriptor index to write |
| cfg_base | input | PA_W | Physical start address to write |
| cfg_limit | input | OFF_W+1 | Segment length to write |
| cfg_present | input | 1 | Present flag to write |
| cfg_perm | input | 3 | Permission bits to write (bit 0 R, bit 1 W, bit 2 X) |
| cfg_cnt_we | input | 1 | Write enable for the segment-count register |
| cfg_cnt | input | SEG_W+1 | New segment count |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access code (0 R, 1 W, 2 X, 3 reserved) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_fault | output | 3 | Fault code (0 none, 1 range, 2 not present, 3 length, 4 permission) |
| rsp_paddr | output | PA_W | Translated physical address, 0 on fault |

## Verification
The hardest case to reach from the ports is a configuration write that lands on the same edge as the lookup it would change. The stimulus must time a descriptor rewrite and a request to the same segment onto one edge, then check that the old contents decide that response and the new contents decide the next one. Random traffic rarely hits the other hard cases: offsets exactly at the length, lengths of zero or the full range, and descriptors that fail several checks at once. The bench therefore biases offsets toward each length and adds directed multi-fault descriptors. Stall windows with a competing request waiting cover the hold and acceptance rules.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_LENGTH  = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/segxl_table.sv
module segxl_table #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent_we,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W:0]   wr_limit,
  input  logic             wr_present,
  input  logic [2:0]       wr_perm,
  input  logic             cnt_we,
  input  logic [SEG_W:0]   wr_cnt,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W:0]   rd_limit,
  output logic             rd_present,
  output logic [2:0]       rd_perm,
  output logic [SEG_W:0]   seg_cnt
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0] base_q    [NSEG];
  logic [OFF_W:0]  limit_q   [NSEG];
  logic            present_q [NSEG];
  logic [2:0]      perm_q    [NSEG];
  logic [SEG_W:0]  cnt_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic ent_en;
    assign ent_en = ent_we && (wr_idx == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        present_q[g] <= 1'b0;
        perm_q[g]    <= '0;
      end else if (ent_en) begin
        base_q[g]    <= wr_base;
        limit_q[g]   <= wr_limit;
        present_q[g] <= wr_present;
        perm_q[g]    <= wr_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= wr_cnt;
  end

  assign rd_base    = base_q[rd_idx];
  assign rd_limit   = limit_q[rd_idx];
  assign rd_present = present_q[rd_idx];
  assign rd_perm    = perm_q[rd_idx];
  assign seg_cnt    = cnt_q;
endmodule

// File: rtl/segxl_check.sv
module segxl_check
  import segxl_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  input  logic [SEG_W:0]   seg_cnt,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W:0]   limit,
  input  logic             present,
  input  logic [2:0]       perm,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);
  logic perm_ok;

  always_comb begin
    unique case (access_e'(acc))
      ACC_READ:  perm_ok = perm[PERM_R];
      ACC_WRITE: perm_ok = perm[PERM_W];
      ACC_EXEC:  perm_ok = perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if ({1'b0, seg} >= seg_cnt)     fault = FLT_RANGE;
    else if (!present)              fault = FLT_ABSENT;
    else if ({1'b0, off} >= limit)  fault = FLT_LENGTH;
    else if (!perm_ok)              fault = FLT_PERM;
    else                            fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? base + {{(PA_W-OFF_W){1'b0}}, off} : '0;
endmodule

// File: rtl/segxl_unit.sv
module segxl_unit
  import segxl_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ent_we,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W:0]   cfg_limit,
  input  logic             cfg_present,
  input  logic [2:0]       cfg_perm,
  input  logic             cfg_cnt_we,
  input  logic [SEG_W:0]   cfg_cnt,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [2:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [PA_W-1:0] ent_base;
  logic [OFF_W:0]  ent_limit;
  logic            ent_present;
  logic [2:0]      ent_perm;
  logic [SEG_W:0]  seg_cnt;
  fault_e          chk_fault;
  logic [PA_W-1:0] chk_paddr;

  logic            accept;
  logic            vld_d, vld_q;
  logic [2:0]      fault_d, fault_q;
  logic [PA_W-1:0] paddr_d, paddr_q;

  segxl_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .ent_we(cfg_ent_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_present(cfg_present), .wr_perm(cfg_perm),
    .cnt_we(cfg_cnt_we), .wr_cnt(cfg_cnt),
    .rd_idx(req_seg), .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_present(ent_present), .rd_perm(ent_perm), .seg_cnt(seg_cnt)
  );

  segxl_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) check_i (
    .seg(req_seg), .off(req_off), .acc(req_acc), .seg_cnt(seg_cnt),
    .base(ent_base), .limit(ent_limit), .present(ent_present),
    .perm(ent_perm), .fault(chk_fault), .paddr(chk_paddr)
  );

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    vld_d   = vld_q;
    fault_d = fault_q;
    paddr_d = paddr_q;
    if (accept) begin
      vld_d   = 1'b1;
      fault_d = chk_fault;
      paddr_d = chk_paddr;
    end else if (rsp_ready) begin
      vld_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      fault_q <= '0;
      paddr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (accept) begin
        fault_q <= fault_d;
        paddr_q <= paddr_d;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;
endmodule

// File: rtl/segxl_unit_chk.sv
module segxl_unit_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_paddr
);
  p_accept_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)));

  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));

  p_fault_no_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));
endmodule

bind segxl_unit segxl_unit_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr)
);

// File: tb/segxl_unit_tb_top.sv
module segxl_unit_tb_top;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;
  localparam int NSEG  = 1 << SEG_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_ent_we = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFF_W:0]   cfg_limit = '0;
  logic             cfg_present = 1'b0;
  logic [2:0]       cfg_perm = '0;
  logic             cfg_cnt_we = 1'b0;
  logic [SEG_W:0]   cfg_cnt = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [2:0]       rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;

  always #4 clk = ~clk;

  segxl_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (.*);

  logic [PA_W-1:0] m_base [NSEG];
  logic [OFF_W:0]  m_lim  [NSEG];
  logic            m_pres [NSEG];
  logic [2:0]      m_perm [NSEG];
  logic [SEG_W:0]  m_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [2:0] exp_fault(input logic [SEG_W-1:0] s,
      input logic [OFF_W-1:0] o, input logic [1:0] a);
    logic ok;
    ok = (a == 2'd3) ? 1'b0 : m_perm[s][a];
    if ({1'b0, s} >= m_cnt)       return 3'd1;
    if (!m_pres[s])               return 3'd2;
    if ({1'b0, o} >= m_lim[s])    return 3'd3;
    if (!ok)                      return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [PA_W-1:0] exp_paddr(input logic [SEG_W-1:0] s,
      input logic [OFF_W-1:0] o, input logic [1:0] a);
    if (exp_fault(s, o, a) != 3'd0) return '0;
    return m_base[s] + PA_W'(o);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_ent(input int i, input logic [PA_W-1:0] b,
      input logic [OFF_W:0] l, input logic p, input logic [2:0] pm);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_idx = SEG_W'(i); cfg_base = b;
    cfg_limit = l; cfg_present = p; cfg_perm = pm;
    @(negedge clk);
    cfg_ent_we = 1'b0;
    m_base[i] = b; m_lim[i] = l; m_pres[i] = p; m_perm[i] = pm;
  endtask

  task automatic write_cnt(input logic [SEG_W:0] c);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_cnt = c;
    @(negedge clk);
    cfg_cnt_we = 1'b0;
    m_cnt = c;
  endtask

  task automatic lookup(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
      input logic [1:0] a, input string tag);
    logic [2:0] ef;
    logic [PA_W-1:0] ep;
    ef = exp_fault(s, o, a);
    ep = exp_paddr(s, o, a);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_fault == ef && rsp_paddr == ep, tag,
          int'({rsp_valid, rsp_fault, rsp_paddr}), int'({1'b1, ef, ep}));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] f0;
    logic [PA_W-1:0] p0;
    logic [2:0] ef;
    logic [PA_W-1:0] ep;
    void'($urandom(32'd4242));
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0; m_perm[i] = '0;
    end
    m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!rsp_valid && req_ready, "R1 reset outputs",
          int'({rsp_valid, req_ready}), 1);
    lookup(3'd0, 12'd0, 2'd0, "R1 R4 count zero gives range");
    write_cnt(4'd8);
    lookup(3'd5, 12'd1, 2'd0, "R1 R5 reset descriptors absent");

    // Directed descriptors
    write_ent(0, 16'h1000, 13'd256, 1'b1, 3'b001);
    write_ent(1, 16'hFF00, 13'd4096, 1'b1, 3'b111);
    write_ent(2, 16'h0200, 13'd0, 1'b1, 3'b111);
    write_ent(3, 16'h4000, 13'd16, 1'b0, 3'b000);
    lookup(3'd0, 12'd255, 2'd0, "R9 last byte in range");
    lookup(3'd0, 12'd256, 2'd0, "R6 offset equals length");
    lookup(3'd0, 12'd10, 2'd1, "R7 write not permitted");
    lookup(3'd0, 12'd10, 2'd2, "R7 exec not permitted");
    lookup(3'd1, 12'd4095, 2'd2, "R9 wraparound full length");
    lookup(3'd1, 12'd3, 2'd3, "R7 reserved access");
    lookup(3'd2, 12'd0, 2'd0, "R6 zero length");
    lookup(3'd3, 12'd100, 2'd3, "R8 absent beats length and perm");
    lookup(3'd0, 12'd300, 2'd1, "R8 length beats perm");
    write_cnt(4'd2);
    lookup(3'd3, 12'd100, 2'd3, "R8 R11 range beats absent");
    lookup(3'd1, 12'd5, 2'd0, "R11 below count passes");
    lookup(3'd2, 12'd0, 2'd0, "R11 at count rejected");
    write_cnt(4'd8);

    // R10: write on the same edge as an accepted lookup
    ef = exp_fault(3'd0, 12'd20, 2'd1);
    ep = exp_paddr(3'd0, 12'd20, 2'd1);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_idx = 3'd0; cfg_base = 16'h2222;
    cfg_limit = 13'd64; cfg_present = 1'b1; cfg_perm = 3'b010;
    req_valid = 1'b1; req_seg = 3'd0; req_off = 12'd20; req_acc = 2'd1;
    @(negedge clk);
    cfg_ent_we = 1'b0; req_valid = 1'b0;
    check(rsp_valid && rsp_fault == ef && rsp_paddr == ep, "R10 same edge old",
          int'({rsp_fault, rsp_paddr}), int'({ef, ep}));
    m_base[0] = 16'h2222; m_lim[0] = 13'd64; m_pres[0] = 1'b1; m_perm[0] = 3'b010;
    lookup(3'd0, 12'd20, 2'd1, "R10 next lookup new");
    ef = exp_fault(3'd1, 12'd7, 2'd0);
    ep = exp_paddr(3'd1, 12'd7, 2'd0);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_cnt = 4'd1;
    req_valid = 1'b1; req_seg = 3'd1; req_off = 12'd7; req_acc = 2'd0;
    @(negedge clk);
    cfg_cnt_we = 1'b0; req_valid = 1'b0;
    check(rsp_valid && rsp_fault == ef && rsp_paddr == ep, "R10 count same edge",
          int'({rsp_fault, rsp_paddr}), int'({ef, ep}));
    m_cnt = 4'd1;
    lookup(3'd1, 12'd7, 2'd0, "R10 R11 count next lookup");
    write_cnt(4'd8);

    // R2/R3: stall with competing request
    rsp_ready = 1'b0;
    ef = exp_fault(3'd1, 12'd9, 2'd0);
    ep = exp_paddr(3'd1, 12'd9, 2'd0);
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd1; req_off = 12'd9; req_acc = 2'd0;
    @(negedge clk);
    req_seg = 3'd0; req_off = 12'd1; req_acc = 2'd1;
    f0 = rsp_fault; p0 = rsp_paddr;
    check(rsp_valid && !req_ready && f0 == ef && p0 == ep, "R2 R3 stalled rsp",
          int'({rsp_valid, req_ready, f0, p0}), int'({1'b1, 1'b0, ef, ep}));
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_fault == f0 && rsp_paddr == p0, "R3 hold under stall",
          int'({rsp_fault, rsp_paddr}), int'({f0, p0}));
    ef = exp_fault(3'd0, 12'd1, 2'd1);
    ep = exp_paddr(3'd0, 12'd1, 2'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_fault == ef && rsp_paddr == ep, "R2 waiting request taken",
          int'({rsp_fault, rsp_paddr}), int'({ef, ep}));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R2 drained", int'({rsp_valid, req_ready}), 1);

    // Random traffic
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) begin
        write_ent(int'($urandom_range(0, NSEG-1)), PA_W'($urandom),
                  13'($urandom_range(0, 4096)), ($urandom_range(0, 3) != 0),
                  3'($urandom));
      end else if (r == 1) begin
        write_cnt(4'($urandom_range(0, 8)));
      end else begin
        logic [SEG_W-1:0] s;
        logic [OFF_W-1:0] o;
        s = SEG_W'($urandom);
        if ($urandom_range(0, 1) == 1 && m_lim[s] != 0)
          o = OFF_W'(int'(m_lim[s]) - int'($urandom_range(0, 1)));
        else
          o = OFF_W'($urandom);
        lookup(s, o, 2'($urandom), "R4 R5 R6 R7 R8 R9 random");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule